// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a local-oscillator clock down to the comparison rate of a tuning synthesizer and gives the phase detector one pulse per division cycle. It has three band settings. In the lowest band a 12-bit main counter divides the input directly. In the middle band a 16/17 dual-modulus prescaler sits in front of the main counter, and a 4-bit swallow counter keeps it at modulus 17 for the first A prescaler periods of each cycle. The high band adds a fixed divide-by-two stage ahead of that chain.

A 16-bit divide word holds the main value N in bits [15:4] and the swallow value A in bits [3:0]. A load strobe captures the word and the band code into a pending register. The running cycle always finishes with its old setting, and the pending setting takes over at the next cycle boundary. A main value of zero parks the divider so that it gives no pulses. The divider leaves that state at the first boundary that sees a non-zero main value.

Top module: `pulse_swallow_divider`

## Requirements
- R1: With band code 0 (direct), the output pulses every N input clocks, where N is divWord[15:4]. divWord[3:0] has no effect on the period.
- R2: With band code 1 (middle), pulses are 16·N + A input clocks apart, where A is divWord[3:0] and A ≤ N.
- R3: With band code 2 (high), pulses are 2·(16·N + A) input clocks apart, and no two pulses fall within three consecutive clocks.
- R4: In the swallow bands, A = 0 gives a period of exactly 16·N prescaler input cycles, and A = N gives exactly 17·N.
- R5: divPulse is high for exactly one input clock per division cycle whenever the period is at least 2.
- R6: A word loaded during a cycle does not change that cycle's length. The next cycle runs with the new word.
- R7: A main value of 0 stops the output once the current cycle has ended. Loading a non-zero word afterwards restarts pulsing at that word's ratio.
- R8: ratioErr is registered one clock after loadStb. It is 1 when the loaded band code is 3 (reserved), or when the band is a swallow band (1 or 2) and A > N. Otherwise it is 0, and it keeps its value while loadStb is low.
- R9: While rstN is low, divPulse and ratioErr are 0. After reset the divider is stopped with a main value of 0, so it gives no pulses until a word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local-oscillator clock being divided |
| rstN | input | 1 | Asynchronous active-low reset |
| bandSel | input | 2 | Band code: 0 direct, 1 middle, 2 high, 3 reserved |
| divWord | input | 16 | Divide word: N in [15:4], A in [3:0] |
| loadStb | input | 1 | Captures bandSel and divWord into the pending setting |
| divPulse | output | 1 | One-clock pulse at the end of each division cycle |
| ratioErr | output | 1 | Flag for an invalid loaded word |

## Verification
ratioErr is due on the clock edge that samples loadStb. The bench therefore reads it at the falling edge that follows that strobe. A new word starts to count at the first cycle boundary at least one edge after the strobe is registered. The bench lets one more clock pass after each load, waits for the next pulse, and only then measures the pulse-to-pulse spacing against 16·N + A, twice that, or N. For the mid-cycle load case, the bench times the period that is already running from its opening pulse. It expects the old ratio for that period and the new ratio for the one after it.

// File: rtl/psd_pkg.sv
package psd_pkg;

  typedef enum logic [1:0] {
    BAND_DIRECT = 2'd0,
    BAND_MID    = 2'd1,
    BAND_HIGH   = 2'd2,
    BAND_RSVD   = 2'd3
  } band_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;  // reload counters from the pending word
    logic advance;  // count one input clock
  } strobe_t;

endpackage

// File: rtl/psd_datapath.sv
module psd_datapath
  import psd_pkg::*;
#(
  parameter int MAIN_W = 12,
  parameter int SW_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  band_e             actBand,
  input  logic [MAIN_W-1:0] loadMain,
  input  logic [SW_W-1:0]   loadSw,
  output logic              termHit,
  output logic              mainZero
);
  localparam int PRE_W = SW_W + 1;
  localparam logic [PRE_W-1:0] LAST_LO = PRE_W'((1 << SW_W) - 1);
  localparam logic [PRE_W-1:0] LAST_HI = PRE_W'(1 << SW_W);

  logic [MAIN_W-1:0] mainCnt;
  logic [SW_W-1:0]   swCnt;
  logic [PRE_W-1:0]  preCnt;
  logic              halfTgl;

  logic isDirect, tick, preLast, mainOne, swBusy;

  always_comb begin
    isDirect = (actBand == BAND_DIRECT);
    tick     = (actBand == BAND_HIGH || actBand == BAND_RSVD) ? halfTgl : 1'b1;
    swBusy   = (swCnt != '0);
    preLast  = (preCnt == (swBusy ? LAST_HI : LAST_LO));
    mainOne  = (mainCnt == MAIN_W'(1));
    mainZero = (mainCnt == '0);
    termHit  = isDirect ? mainOne : (tick && preLast && mainOne);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainCnt <= '0;
      swCnt   <= '0;
      preCnt  <= '0;
      halfTgl <= 1'b0;
    end else if (stb.restart) begin
      mainCnt <= loadMain;
      swCnt   <= loadSw;
      preCnt  <= '0;
      halfTgl <= 1'b0;
    end else if (stb.advance) begin
      halfTgl <= ~halfTgl;
      if (isDirect) begin
        mainCnt <= mainCnt - 1'b1;
      end else if (tick) begin
        if (preLast) begin
          preCnt  <= '0;
          mainCnt <= mainCnt - 1'b1;
          if (swBusy) swCnt <= swCnt - 1'b1;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/psd_ctrl.sv
module psd_ctrl
  import psd_pkg::*;
#(
  parameter int MAIN_W = 12,
  parameter int SW_W   = 4,
  localparam int WORD_W = MAIN_W + SW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic [1:0]        bandSel,
  input  logic [WORD_W-1:0] divWord,
  input  logic              termHit,
  input  logic              mainZero,
  output strobe_t           stb,
  output band_e             actBand,
  output logic [MAIN_W-1:0] loadMain,
  output logic [SW_W-1:0]   loadSw,
  output logic              divPulse,
  output logic              ratioErr
);
  logic [MAIN_W-1:0] pendMain;
  logic [SW_W-1:0]   pendSw;
  band_e             pendBand;

  band_e             inBand;
  logic [MAIN_W-1:0] inMain;
  logic [SW_W-1:0]   inSw;
  logic              wordBad;

  always_comb begin
    inBand  = band_e'(bandSel);
    inMain  = divWord[WORD_W-1:SW_W];
    inSw    = divWord[SW_W-1:0];
    wordBad = (inBand == BAND_RSVD) ||
              ((inBand != BAND_DIRECT) && (MAIN_W'(inSw) > inMain));
    stb.restart = termHit || mainZero;
    stb.advance = !(termHit || mainZero);
    loadMain = pendMain;
    loadSw   = pendSw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMain <= '0;
      pendSw   <= '0;
      pendBand <= BAND_DIRECT;
      actBand  <= BAND_DIRECT;
      divPulse <= 1'b0;
      ratioErr <= 1'b0;
    end else begin
      if (loadStb) begin
        pendMain <= inMain;
        pendSw   <= inSw;
        pendBand <= inBand;
        ratioErr <= wordBad;
      end
      if (stb.restart) actBand <= pendBand;
      divPulse <= termHit;
    end
  end

endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import psd_pkg::*;
#(
  parameter int MAIN_W = 12,
  parameter int SW_W   = 4,
  localparam int WORD_W = MAIN_W + SW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        bandSel,
  input  logic [WORD_W-1:0] divWord,
  input  logic              loadStb,
  output logic              divPulse,
  output logic              ratioErr
);
  strobe_t           stb;
  band_e             actBand;
  logic [MAIN_W-1:0] loadMain;
  logic [SW_W-1:0]   loadSw;
  logic              termHit;
  logic              mainZero;

  psd_ctrl #(.MAIN_W(MAIN_W), .SW_W(SW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .bandSel(bandSel),
    .divWord(divWord), .termHit(termHit), .mainZero(mainZero),
    .stb(stb), .actBand(actBand), .loadMain(loadMain), .loadSw(loadSw),
    .divPulse(divPulse), .ratioErr(ratioErr)
  );

  psd_datapath #(.MAIN_W(MAIN_W), .SW_W(SW_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .actBand(actBand),
    .loadMain(loadMain), .loadSw(loadSw),
    .termHit(termHit), .mainZero(mainZero)
  );

endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
  parameter int MAIN_W = 12,
  parameter int SW_W   = 4,
  localparam int WORD_W = MAIN_W + SW_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        bandSel,
  input logic [WORD_W-1:0] divWord,
  input logic              loadStb,
  input logic              divPulse,
  input logic              ratioErr,
  input logic [1:0]        actBand
);
  assert_err_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> ratioErr == (($past(bandSel) == 2'd3) ||
                  (($past(bandSel) != 2'd0) &&
                   (MAIN_W'($past(divWord[SW_W-1:0])) > $past(divWord[WORD_W-1:SW_W])))));

  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !loadStb |=> $stable(ratioErr));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    (divPulse && actBand != 2'd0) |=> !divPulse);

  assert_high_gap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (divPulse && actBand[1]) |=> !divPulse ##1 !divPulse);

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_R9: assert (!divPulse && !ratioErr);
    end
  end

endmodule

bind pulse_swallow_divider psd_checker #(.MAIN_W(MAIN_W), .SW_W(SW_W)) u_chk (
  .clk(clk), .rstN(rstN), .bandSel(bandSel), .divWord(divWord),
  .loadStb(loadStb), .divPulse(divPulse), .ratioErr(ratioErr),
  .actBand(actBand)
);

// File: tb/pulse_swallow_divider_bench.sv
module pulse_swallow_divider_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  bandSel = 2'd0;
  logic [15:0] divWord = 16'd0;
  logic        loadStb = 1'b0;
  logic        divPulse, ratioErr;

  int nChk = 0;
  int nFail = 0;
  bit timedOut = 0;

  always #2 clk = ~clk;  // 250 MHz

  pulse_swallow_divider u_pulse_swallow_divider (
    .clk(clk), .rstN(rstN), .bandSel(bandSel), .divWord(divWord),
    .loadStb(loadStb), .divPulse(divPulse), .ratioErr(ratioErr)
  );

  function automatic int expRatio(input int band, input int n, input int a);
    if (band == 0) return n;
    if (band == 1) return 16 * n + a;
    return 2 * (16 * n + a);
  endfunction

  function automatic bit expErr(input int band, input int n, input int a);
    return (band == 3) || (band != 0 && a > n);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic loadWord(input int band, input int n, input int a);
    @(negedge clk);
    bandSel = band[1:0];
    divWord = {n[11:0], a[3:0]};
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  task automatic waitPulse();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!divPulse && guard < 20000);
  endtask

  // Called at a pulse; returns clocks until the next pulse and checks width
  task automatic measure(input string req, output int interval);
    int cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) chk(req, "pulse width", int'(divPulse), 0);
    end while (!divPulse && cnt < 20000);
    interval = cnt;
  endtask

  task automatic runCase(input string req, input int band, input int n, input int a);
    int iv;
    loadWord(band, n, a);
    @(negedge clk);
    waitPulse();
    measure(req, iv);
    chk(req, "period", iv, expRatio(band, n, a));
  endtask

  task automatic mainSeq();
    int iv;
    int pulses;
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9", "divPulse in reset", int'(divPulse), 0);
    chk("R9", "ratioErr in reset", int'(ratioErr), 0);
    rstN = 1'b1;
    pulses = 0;
    repeat (60) begin @(negedge clk); pulses += int'(divPulse); end
    chk("R9", "pulses after reset", pulses, 0);

    // Directed cases
    runCase("R1", 0, 5, 9);
    runCase("R1", 0, 7, 0);
    runCase("R4", 1, 3, 0);
    runCase("R4", 1, 4, 4);
    runCase("R2", 1, 10, 7);
    runCase("R3", 2, 2, 1);
    runCase("R3", 2, 5, 5);

    // R6: load during a running cycle (mid N=6 A=2 -> 98)
    runCase("R6", 1, 6, 2);
    begin
      int cnt = 0;
      do begin
        @(negedge clk);
        cnt++;
        if (cnt == 3) begin bandSel = 2'd0; divWord = {12'd20, 4'd3}; loadStb = 1'b1; end
        if (cnt == 4) loadStb = 1'b0;
      end while (!divPulse && cnt < 20000);
      chk("R6", "old period kept", cnt, 98);
      measure("R6", iv);
      chk("R6", "new period", iv, 20);
    end

    // R7: stop with N=0, then restart
    loadWord(1, 0, 0);
    pulses = 0;
    repeat (20 + 200) begin @(negedge clk); pulses += int'(divPulse); end
    chk("R7", "pulses after stop", pulses, 1);
    runCase("R7", 1, 2, 1);

    // R8: error flag
    loadWord(1, 3, 5);
    chk("R8", "A>N mid", int'(ratioErr), 1);
    loadWord(3, 8, 2);
    chk("R8", "reserved band", int'(ratioErr), 1);
    loadWord(0, 1, 15);
    chk("R8", "direct A>N", int'(ratioErr), 0);
    repeat (20) @(negedge clk);
    chk("R8", "hold low", int'(ratioErr), 0);
    loadWord(2, 2, 9);
    chk("R8", "A>N high", int'(ratioErr), 1);
    repeat (20) @(negedge clk);
    chk("R8", "hold high", int'(ratioErr), 1);
    loadWord(2, 9, 9);
    chk("R8", "A=N ok", int'(ratioErr), 0);

    // Random cases
    void'($urandom(32'd4242));
    for (int i = 0; i < 24; i++) begin
      int band = $urandom_range(0, 2);
      int n, a;
      if (band == 0) begin
        n = $urandom_range(2, 300);
        a = $urandom_range(0, 15);
      end else begin
        n = $urandom_range(1, 40);
        a = $urandom_range(0, (n < 15) ? n : 15);
      end
      runCase(band == 0 ? "R1" : (band == 1 ? "R2" : "R3"), band, n, a);
      chk("R8", "valid word flag", int'(ratioErr), int'(expErr(band, n, a)));
    end
  endtask

  initial begin
    fork
      mainSeq();
      begin
        repeat (190000) @(posedge clk);
        timedOut = 1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      nChk++;
      nFail++;
      $display("FAIL R1 watchdog actual=expired expected=complete");
    end
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule